// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is an 18-bit first-in first-out buffer with one clock for the writer and one for the reader. Words go in on the write clock when the active-low write enable is asserted and the buffer has room. They come out on the read clock, oldest first, when the active-low read enable is asserted and the buffer holds data. Each pointer crosses into the other domain as a Gray code through a synchronizer chain. Because of this, a domain sees the other side's progress a couple of its own clocks late. A flag can therefore clear late, but it never reports data or space that is not there.

The block has five active-low status outputs: empty, full, half-full, almost-empty and almost-full. The two "almost" thresholds sit in a small offset store. While the active-low load strobe is held, write-port cycles program that store and read-port cycles return its contents on the data output. In both directions the two offsets are accessed alternately: almost-empty first, then almost-full. A timing-mode input chooses how the two threshold flags are produced. They are either registered in their own clock domain or formed combinationally from the raw fill level. A retransmit strobe sends the reader back to the first location, so that data is read again. This is meant for bursts no longer than the depth since reset. An active-low output enable gates the data output. High impedance is modelled as a drive-valid signal together with a zeroed bus.

The reset is synchronous and active low, and it must be held across edges of both clocks. The buffer must be reset before it is first used.

Top module: `dcf_fifo`

## Requirements
- R1: A rising write-clock edge stores `wr_data` only when `wr_en_n` is 0, `load_n` is 1 and `full_n` is 1; a write attempted while full is dropped and leaves the stored contents unchanged.
- R2: A rising read-clock edge with `rd_en_n` 0, `load_n` 1, `retx_n` 1 and `empty_n` 1 loads the oldest unread word into the output register; a read while empty leaves the output and read position unchanged.
- R3: `full_n` is 0 exactly when the write pointer minus the synchronized read pointer equals DEPTH; a read becomes visible to the write side two write-clock edges after the edge that performed it.
- R4: `empty_n` is 0 exactly when the synchronized write pointer equals the read pointer; a write becomes visible to the read side two read-clock edges after the edge that performed it.
- R5: `half_n` is 0 when the write-side fill level is greater than DEPTH/2, and 1 otherwise.
- R6: While `load_n` is 0, each write-port cycle with `wr_en_n` 0 writes `wr_data[PTR_W-1:0]` to one offset and does not touch the FIFO. The target alternates, almost-empty first and then almost-full.
- R7: While `load_n` is 0 and `retx_n` is 1, each read-port cycle with `rd_en_n` 0 puts one offset, zero-extended, into the output register and consumes no FIFO word. The source alternates, almost-empty first and then almost-full.
- R8: With `sync_mode` 0, `ae_n` is 0 when the raw fill level (write pointer minus read pointer) is at most the almost-empty offset. `af_n` is 0 when DEPTH minus that raw fill is at most the almost-full offset. Both are combinational.
- R9: With `sync_mode` 1, `ae_n` is a read-clock register of the read-side comparison against the almost-empty offset, and `af_n` is a write-clock register of the write-side free-space comparison against the almost-full offset.
- R10: Reset gives `empty_n`=0, `full_n`=1, `half_n`=1, `ae_n`=0, `af_n`=1, a zero output register, both offsets equal to DEF_OFF, and both alternation selects pointing at almost-empty.
- R11: `retx_n` 0 on a read-clock edge sets the read position to location 0. It takes priority over any read or load read in the same cycle.
- R12: With `oe_n` 1, `rd_data` is all zeros and `rd_drive` is 0. With `oe_n` 0, `rd_data` shows the output register and `rd_drive` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, seen by both domains |
| wr_data | input | DATA_W | Word to store, or offset value under load |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| load_n | input | 1 | Active-low offset-store access strobe |
| retx_n | input | 1 | Active-low retransmit (rewind read position) |
| oe_n | input | 1 | Active-low output enable |
| sync_mode | input | 1 | 1: registered threshold flags, 0: combinational |
| rd_data | output | DATA_W | Output word, zero when not driven |
| rd_drive | output | 1 | High when rd_data drives the bus |
| empty_n | output | 1 | Active-low empty, read domain |
| full_n | output | 1 | Active-low full, write domain |
| half_n | output | 1 | Active-low more-than-half-full, write domain |
| ae_n | output | 1 | Active-low almost-empty |
| af_n | output | 1 | Active-low almost-full |

## Verification
The bench drives writes past full and reads past empty. A design that let a blocked write through would overwrite unread data or move the pointer. A design that let a blocked read through would corrupt later output words. The two-edge visibility delay through the synchronizers is checked clock by clock. A flag that cleared early, or was tied to the local pointer, would show up as a flag mismatch a cycle or two after each transfer. Offset loads and readbacks are checked for their alternation order and for leaving the FIFO untouched. Threshold flags are compared in both timing modes, where a wrong mode mux or a missing register shows as a one-cycle skew. Retransmit is issued together with a read, so that a wrong priority or a wrong rewind target shows up in the repeated data stream.

// File: rtl/dcf_pkg.sv
// Package: shared types for the dual-clock FIFO.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package dcf_pkg;
    // Threshold flag timing choice, matches the sync_mode input level.
    typedef enum logic {
        FLAG_COMB = 1'b0,
        FLAG_REG  = 1'b1
    } flag_mode_e;

    // Which offset the next load access targets.
    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } off_sel_e;
endpackage

// File: rtl/dcf_sync.sv
// Module: dcf_sync
// Multi-flop synchronizer for a Gray-coded pointer bus.
// Assumes the input changes by at most one bit per source clock,
// so any sampled value is either the old or the new pointer.
module dcf_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First capture flop of the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Further resolution stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[gi] <= '0;
                    else        chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
// Module: dcf_mem
// Register-array storage written on the write clock, read
// combinationally by address; the read side registers the word.
// Assumes the writer never writes a location the reader is fetching,
// which the full/empty logic guarantees.
module dcf_mem #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    // Store one word per accepted write.
    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Present the word at the read address.
    assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
// Module: dcf_wr_side
// Write-domain control: pointer, full and half-full flags, the
// programmable offset store and the almost-full flag.
// Assumes rd_gray_s is already synchronized to clk; rd_ptr_raw is the
// unsynchronized read pointer, used only for combinational flag timing.
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int DEPTH   = 16,
    parameter int DEF_OFF = 2,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              load_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_gray_s,
    input  logic [PTR_W-1:0]  rd_ptr_raw,
    input  logic              sync_mode,
    output logic [PTR_W-1:0]  w_ptr,
    output logic [PTR_W-1:0]  w_gray,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic              full_n,
    output logic              half_n,
    output logic              af_n,
    output logic [PTR_W-1:0]  ae_off,
    output logic [PTR_W-1:0]  af_off
);
    logic [PTR_W-1:0] rd_bin_s;
    logic [PTR_W-1:0] fill_w;
    logic [PTR_W-1:0] free_w;
    logic [PTR_W-1:0] raw_fill;
    logic             is_full;
    logic             push;
    logic             ld_wr;
    logic             af_q;
    logic             af_comb;
    off_sel_e         wsel;
    flag_mode_e       fmode;

    // Decode the synchronized Gray read pointer to binary.
    always_comb begin
        rd_bin_s[PTR_W-1] = rd_gray_s[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            rd_bin_s[i] = rd_bin_s[i+1] ^ rd_gray_s[i];
        end
    end

    assign fill_w   = w_ptr - rd_bin_s;
    assign free_w   = PTR_W'(DEPTH) - fill_w;
    assign is_full  = (fill_w == PTR_W'(DEPTH));
    assign push     = !wr_en_n && load_n && !is_full;
    assign ld_wr    = !wr_en_n && !load_n;
    assign raw_fill = w_ptr - rd_ptr_raw;
    assign fmode    = flag_mode_e'(sync_mode);

    // Advance the write pointer and its Gray copy on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_ptr  <= '0;
            w_gray <= '0;
        end else if (push) begin
            w_ptr  <= w_ptr + 1'b1;
            w_gray <= (w_ptr + 1'b1) ^ ((w_ptr + 1'b1) >> 1);
        end
    end

    // Program the offsets alternately under the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_off <= PTR_W'(DEF_OFF);
            af_off <= PTR_W'(DEF_OFF);
            wsel   <= SEL_AE;
        end else if (ld_wr) begin
            if (wsel == SEL_AE) ae_off <= wr_data[PTR_W-1:0];
            else                af_off <= wr_data[PTR_W-1:0];
            wsel <= (wsel == SEL_AE) ? SEL_AF : SEL_AE;
        end
    end

    // Registered almost-full from the write-side free space.
    always_ff @(posedge clk) begin
        if (!rst_n) af_q <= 1'b1;
        else        af_q <= !(free_w <= af_off);
    end

    // Combinational almost-full from the raw pointer difference.
    assign af_comb = !((PTR_W'(DEPTH) - raw_fill) <= af_off);

    assign af_n      = (fmode == FLAG_REG) ? af_q : af_comb;
    assign full_n    = !is_full;
    assign half_n    = !(fill_w > PTR_W'(DEPTH / 2));
    assign mem_we    = push;
    assign mem_waddr = w_ptr[ADDR_W-1:0];
endmodule

// File: rtl/dcf_rd_side.sv
// Module: dcf_rd_side
// Read-domain control: pointer, retransmit, empty flag, almost-empty
// flag and the output register (FIFO word or offset readback).
// Assumes wr_gray_s is synchronized to clk and that the offsets are
// quasi-static whenever they are read back here.
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int DEPTH   = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_n,
    input  logic              load_n,
    input  logic              retx_n,
    input  logic [PTR_W-1:0]  wr_gray_s,
    input  logic [PTR_W-1:0]  wr_ptr_raw,
    input  logic              sync_mode,
    input  logic [PTR_W-1:0]  ae_off,
    input  logic [PTR_W-1:0]  af_off,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [PTR_W-1:0]  r_ptr,
    output logic [PTR_W-1:0]  r_gray,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [DATA_W-1:0] q,
    output logic              empty_n,
    output logic              ae_n
);
    logic [PTR_W-1:0] wr_bin_s;
    logic [PTR_W-1:0] fill_r;
    logic [PTR_W-1:0] raw_fill;
    logic             is_empty;
    logic             rewind;
    logic             pop;
    logic             ld_rd;
    logic             ae_q;
    logic             ae_comb;
    off_sel_e         rsel;
    flag_mode_e       fmode;

    // Decode the synchronized Gray write pointer to binary.
    always_comb begin
        wr_bin_s[PTR_W-1] = wr_gray_s[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            wr_bin_s[i] = wr_bin_s[i+1] ^ wr_gray_s[i];
        end
    end

    assign fill_r   = wr_bin_s - r_ptr;
    assign is_empty = (fill_r == '0);
    assign rewind   = !retx_n;
    assign ld_rd    = retx_n && !rd_en_n && !load_n;
    assign pop      = retx_n && !rd_en_n && load_n && !is_empty;
    assign raw_fill = wr_ptr_raw - r_ptr;
    assign fmode    = flag_mode_e'(sync_mode);

    // Move the read pointer: rewind wins over a normal read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_ptr  <= '0;
            r_gray <= '0;
        end else if (rewind) begin
            r_ptr  <= '0;
            r_gray <= '0;
        end else if (pop) begin
            r_ptr  <= r_ptr + 1'b1;
            r_gray <= (r_ptr + 1'b1) ^ ((r_ptr + 1'b1) >> 1);
        end
    end

    // Load the output register from the array or the offset store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            rsel <= SEL_AE;
        end else if (ld_rd) begin
            q    <= (rsel == SEL_AE) ? DATA_W'(ae_off) : DATA_W'(af_off);
            rsel <= (rsel == SEL_AE) ? SEL_AF : SEL_AE;
        end else if (pop) begin
            q <= mem_rdata;
        end
    end

    // Registered almost-empty from the read-side fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) ae_q <= 1'b0;
        else        ae_q <= !(fill_r <= ae_off);
    end

    // Combinational almost-empty from the raw pointer difference.
    assign ae_comb = !(raw_fill <= ae_off);

    assign ae_n      = (fmode == FLAG_REG) ? ae_q : ae_comb;
    assign empty_n   = !is_empty;
    assign mem_raddr = r_ptr[ADDR_W-1:0];
endmodule

// File: rtl/dcf_fifo.sv
// Module: dcf_fifo (top)
// Dual-clock FIFO with empty/full/half-full and programmable
// almost-empty/almost-full flags, offset load/readback, retransmit
// and a modelled output enable.
// Assumes rst_n is held low across at least SYNC_STAGES+1 edges of
// each clock, and that retransmit follows no more than DEPTH writes
// since reset.
module dcf_fifo #(
    parameter int DATA_W      = 18,
    parameter int DEPTH       = 16,
    parameter int DEF_OFF     = 2,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic              load_n,
    input  logic              retx_n,
    input  logic              oe_n,
    input  logic              sync_mode,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n,
    output logic              ae_n,
    output logic              af_n
);
    logic [PTR_W-1:0]  w_ptr_bin;
    logic [PTR_W-1:0]  w_gray;
    logic [PTR_W-1:0]  r_ptr_bin;
    logic [PTR_W-1:0]  r_gray;
    logic [PTR_W-1:0]  w_gray_at_rd;
    logic [PTR_W-1:0]  r_gray_at_wr;
    logic [PTR_W-1:0]  ae_off;
    logic [PTR_W-1:0]  af_off;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] q_reg;

    dcf_wr_side #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DEF_OFF(DEF_OFF)) u_wr (
        .clk        (wr_clk),
        .rst_n      (rst_n),
        .wr_en_n    (wr_en_n),
        .load_n     (load_n),
        .wr_data    (wr_data),
        .rd_gray_s  (r_gray_at_wr),
        .rd_ptr_raw (r_ptr_bin),
        .sync_mode  (sync_mode),
        .w_ptr      (w_ptr_bin),
        .w_gray     (w_gray),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .full_n     (full_n),
        .half_n     (half_n),
        .af_n       (af_n),
        .ae_off     (ae_off),
        .af_off     (af_off)
    );

    dcf_rd_side #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rst_n),
        .rd_en_n    (rd_en_n),
        .load_n     (load_n),
        .retx_n     (retx_n),
        .wr_gray_s  (w_gray_at_rd),
        .wr_ptr_raw (w_ptr_bin),
        .sync_mode  (sync_mode),
        .ae_off     (ae_off),
        .af_off     (af_off),
        .mem_rdata  (mem_rdata),
        .r_ptr      (r_ptr_bin),
        .r_gray     (r_gray),
        .mem_raddr  (mem_raddr),
        .q          (q_reg),
        .empty_n    (empty_n),
        .ae_n       (ae_n)
    );

    dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (w_gray),
        .q     (w_gray_at_rd)
    );

    dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (r_gray),
        .q     (r_gray_at_wr)
    );

    dcf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .wclk  (wr_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    // Output enable: undriven bus is modelled as zero data, drive low.
    assign rd_data  = oe_n ? '0 : q_reg;
    assign rd_drive = !oe_n;
endmodule

// File: rtl/dcf_fifo_chk.sv
// Module: dcf_fifo_chk
// Assertion checker bound into dcf_fifo; observes ports and pointers.
module dcf_fifo_chk #(
    parameter int PTR_W = 5,
    parameter int DEPTH = 16
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             wr_en_n,
    input logic             rd_en_n,
    input logic             load_n,
    input logic             retx_n,
    input logic             full_n,
    input logic             empty_n,
    input logic [PTR_W-1:0] w_ptr_bin,
    input logic [PTR_W-1:0] r_ptr_bin,
    input logic [PTR_W-1:0] w_gray
);
    // R1: a write attempted while full leaves the write pointer alone.
    p_no_overflow_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!full_n && !wr_en_n) |=> $stable(w_ptr_bin));

    // R2: a read attempted while empty leaves the read pointer alone.
    p_no_underflow_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!empty_n && !rd_en_n && load_n && retx_n) |=> $stable(r_ptr_bin));

    // R3: the true fill never exceeds the depth.
    p_fill_bound_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        PTR_W'(w_ptr_bin - r_ptr_bin) <= PTR_W'(DEPTH));

    // R4: the Gray write pointer moves by at most one bit per clock.
    p_gray_step_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        1'b1 |=> ($countones(w_gray ^ $past(w_gray)) <= 1));

    // R6: load-mode write cycles never push into the FIFO.
    p_load_no_push_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !load_n |=> $stable(w_ptr_bin));

    // R7: load-mode read cycles never pop from the FIFO.
    p_load_no_pop_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!load_n && retx_n) |=> $stable(r_ptr_bin));

    // R11: retransmit returns the read position to location 0.
    p_rewind_r11: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !retx_n |=> (r_ptr_bin == '0));
endmodule

bind dcf_fifo dcf_fifo_chk #(.PTR_W(PTR_W), .DEPTH(DEPTH)) u_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst_n     (rst_n),
    .wr_en_n   (wr_en_n),
    .rd_en_n   (rd_en_n),
    .load_n    (load_n),
    .retx_n    (retx_n),
    .full_n    (full_n),
    .empty_n   (empty_n),
    .w_ptr_bin (w_ptr_bin),
    .r_ptr_bin (r_ptr_bin),
    .w_gray    (w_gray)
);

// File: tb/dcf_fifo_test.sv
// Bench for dcf_fifo: both clocks come from one source so that the
// synchronizer delay is a fixed two edges; a behavioural model runs in
// step and every output is compared on every clock.
module dcf_fifo_test;
    localparam int PERIOD = 10;
    localparam int DW     = 18;
    localparam int DEPTH  = 16;
    localparam int DEFO   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_en_n = 1'b1, rd_en_n = 1'b1, load_n = 1'b1;
    logic          retx_n = 1'b1, oe_n = 1'b0, sync_mode = 1'b1;
    logic [DW-1:0] rd_data;
    logic          rd_drive, empty_n, full_n, half_n, ae_n, af_n;

    int checks = 0;
    int fails  = 0;

    // Behavioural model state.
    logic [DW-1:0] store [DEPTH];
    int            wr_tot, rd_tot, rd_s1, rd_seen, wr_s1, wr_seen;
    int            m_ae_off, m_af_off, m_wsel, m_rsel;
    logic [DW-1:0] m_q;
    bit            m_aeq, m_afq;
    string         dtag = "R2";

    always #(PERIOD/2) clk = ~clk;

    dcf_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .DEF_OFF(DEFO)) uut (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_data(wr_data),
        .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .load_n(load_n),
        .retx_n(retx_n), .oe_n(oe_n), .sync_mode(sync_mode),
        .rd_data(rd_data), .rd_drive(rd_drive), .empty_n(empty_n),
        .full_n(full_n), .half_n(half_n), .ae_n(ae_n), .af_n(af_n)
    );

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Model of one shared clock edge, using the inputs held before it.
    task automatic model_edge();
        int wc, rc, aeo, afo;
        if (!rst_n) begin
            wr_tot = 0; rd_tot = 0; rd_s1 = 0; rd_seen = 0; wr_s1 = 0; wr_seen = 0;
            m_ae_off = DEFO; m_af_off = DEFO; m_wsel = 0; m_rsel = 0;
            m_q = '0; m_aeq = 1'b0; m_afq = 1'b1;
            return;
        end
        wc = wr_tot - rd_seen;
        rc = wr_seen - rd_tot;
        aeo = m_ae_off; afo = m_af_off;
        // flag registers and synchronizers see pre-edge values
        m_aeq = !(rc <= aeo);
        m_afq = !((DEPTH - wc) <= afo);
        rd_seen = rd_s1; rd_s1 = rd_tot;
        wr_seen = wr_s1; wr_s1 = wr_tot;
        // write port
        if (!wr_en_n && !load_n) begin
            if (m_wsel == 0) m_ae_off = int'(wr_data[4:0]);
            else             m_af_off = int'(wr_data[4:0]);
            m_wsel ^= 1;
        end else if (!wr_en_n && wc < DEPTH) begin
            store[wr_tot % DEPTH] = wr_data;
            wr_tot++;
        end
        // read port
        if (!retx_n) begin
            rd_tot = 0;
        end else if (!rd_en_n && !load_n) begin
            m_q = DW'((m_rsel == 0) ? aeo : afo);
            m_rsel ^= 1;
        end else if (!rd_en_n && rc != 0) begin
            m_q = store[rd_tot % DEPTH];
            rd_tot++;
        end
    endtask

    task automatic compare();
        int wc, rc, fill;
        bit e_ae, e_af;
        string ftag;
        wc = wr_tot - rd_seen;
        rc = wr_seen - rd_tot;
        fill = wr_tot - rd_tot;
        ftag = sync_mode ? "R9" : "R8";
        e_ae = sync_mode ? m_aeq : !(fill <= m_ae_off);
        e_af = sync_mode ? m_afq : !((DEPTH - fill) <= m_af_off);
        chk("R4", "empty_n", DW'(empty_n), DW'(rc != 0));
        chk("R3", "full_n",  DW'(full_n),  DW'(wc < DEPTH));
        chk("R5", "half_n",  DW'(half_n),  DW'(!(wc > DEPTH/2)));
        chk(ftag, "ae_n",    DW'(ae_n),    DW'(e_ae));
        chk(ftag, "af_n",    DW'(af_n),    DW'(e_af));
        chk("R12", "rd_drive", DW'(rd_drive), DW'(!oe_n));
        chk(oe_n ? "R12" : dtag, "rd_data", rd_data, oe_n ? '0 : m_q);
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic idle();
        wr_en_n = 1'b1; rd_en_n = 1'b1; load_n = 1'b1; retx_n = 1'b1;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic write_burst(input int n, input logic [DW-1:0] base);
        for (int k = 0; k < n; k++) begin
            wr_en_n = 1'b0; wr_data = base + DW'(k);
            step(1);
        end
        wr_en_n = 1'b1;
    endtask

    task automatic read_burst(input int n);
        for (int k = 0; k < n; k++) begin
            rd_en_n = 1'b0;
            step(1);
        end
        rd_en_n = 1'b1;
    endtask

    initial begin
        // R10: reset state
        do_reset();
        step(1);
        chk("R10", "empty_n after reset", DW'(empty_n), DW'(0));
        chk("R10", "full_n after reset",  DW'(full_n),  DW'(1));
        chk("R10", "half_n after reset",  DW'(half_n),  DW'(1));
        chk("R10", "ae_n after reset",    DW'(ae_n),    DW'(0));
        chk("R10", "af_n after reset",    DW'(af_n),    DW'(1));
        chk("R10", "rd_data after reset", rd_data,      '0);

        // R1, R3, R5: fill past capacity, extra writes dropped
        dtag = "R1";
        write_burst(DEPTH + 4, 18'h2A000);
        step(3);
        // R2, R4: drain past empty; data proves no overwrite (R1)
        read_burst(DEPTH + 4);
        step(3);

        // R6, R7: load offsets then read them back alternately
        dtag = "R6/R7";
        load_n = 1'b0;
        wr_en_n = 1'b0; wr_data = 18'd5; step(1);
        wr_data = 18'd4; step(1);
        wr_en_n = 1'b1;
        rd_en_n = 1'b0; step(2);
        rd_en_n = 1'b1; load_n = 1'b1;
        step(2);

        // R8, R9: threshold flags in registered mode around the offsets
        dtag = "R2";
        sync_mode = 1'b1;
        for (int k = 0; k < 14; k++) begin
            wr_en_n = 1'b0; wr_data = 18'h10000 + DW'(k); step(1);
            wr_en_n = 1'b1; step(1);
        end
        read_burst(6);
        step(2);
        read_burst(8);
        step(3);

        // R8: combinational mode, both directions
        sync_mode = 1'b0;
        write_burst(13, 18'h05500);
        step(2);
        for (int k = 0; k < 13; k++) begin
            rd_en_n = 1'b0; step(1);
            rd_en_n = 1'b1; step(1);
        end
        sync_mode = 1'b1;
        step(2);

        // R1, R2: simultaneous streaming
        for (int k = 0; k < 30; k++) begin
            wr_en_n = 1'b0; rd_en_n = (k % 3 == 2); wr_data = 18'h3C000 + DW'(k);
            step(1);
        end
        idle();
        read_burst(DEPTH);
        step(3);

        // R11: retransmit after reset, with a read in the same cycle
        do_reset();
        dtag = "R11";
        write_burst(6, 18'h01230);
        step(3);
        read_burst(3);
        retx_n = 1'b0; rd_en_n = 1'b0; step(1);
        retx_n = 1'b1; rd_en_n = 1'b1;
        step(2);
        read_burst(7);
        step(2);

        // R12: output disabled while reads continue
        dtag = "R2";
        write_burst(4, 18'h0ABC0);
        step(3);
        oe_n = 1'b1;
        read_burst(2);
        oe_n = 1'b0;
        read_burst(2);
        step(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is reported as a failure.
    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog R10: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule